// File: doc/BRIEF.md
# Program/Erase Completion Status Unit

This block sits beside a flash-style storage array and reports the progress of internal write operations. A host starts an operation by pulsing a start strobe. With the strobe it gives the operation type and the address and data of the last word it wrote. The block then holds a busy state for a number of clock cycles. Each operation type has its own cycle count, set by a parameter. When that count runs out, the block returns to plain read mode without any host action.

While busy, the host has three separate ways to find out when the operation is done. A ready/busy pin is pulled low, in the manner of an open-drain output. Read bit 7 carries a polling value: the inverse of the programmed bit for a program, and zero for an erase. Read bit 6 alternates on every new read. All other read bits, and every bit once the operation has finished, come unchanged from the array data input.

Top module: `pe_status_unit`

## Requirements
- R1: While reset is held and right after it, `busy` is 0, `rb_drive_low` is 0, `rb_level` is 1 and `rd_data` equals `arr_data`.
- R2: A start accepted while idle raises `busy` at the next clock edge. `busy` then stays high for exactly the number of cycles set for the operation. The `start_op` codes are: 0 word program (`T_PROG`), 1 page erase (`T_PAGE`), 2 block erase (`T_BLOCK`), 3 chip erase (`T_CHIP`).
- R3: A start strobe that arrives while `busy` is high is ignored. The running operation keeps its type, its address and data, and its end cycle.
- R4: During a word program, a read whose `rd_addr` equals the captured address returns in bit 7 the complement of bit 7 of the captured data. A read at any other address returns `arr_data[7]` in bit 7.
- R5: During any erase (codes 1, 2 and 3), bit 7 of `rd_data` reads 0 at every address.
- R6: While busy, bit 6 of `rd_data` changes only when `rd_active` rises, and it flips on each such rise. It holds its value while `rd_active` stays high. It starts at 0 when an operation is accepted, so the first read of an operation returns 1.
- R7: While busy, bits other than 7 and 6 equal `arr_data`. When not busy, all of `rd_data` equals `arr_data`, so bit 6 stops changing once the operation is over.
- R8: `rb_drive_low` is 1 exactly while `busy` is 1. `rb_level`, the value seen on the pin with the pull-up applied, is its inverse.
- R9: Asserting `rst_n` low during an operation clears `busy` and the toggle state at once, without waiting for a clock edge, and reads return `arr_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Operation start strobe |
| start_op | input | 2 | Operation type: 0 program, 1 page erase, 2 block erase, 3 chip erase |
| start_addr | input | AW | Address of the last written word |
| start_data | input | DW | Data of the last written word |
| rd_active | input | 1 | Host read is in progress |
| rd_addr | input | AW | Read address |
| arr_data | input | DW | Data read from the array |
| rd_data | output | DW | Data returned to the host |
| busy | output | 1 | Operation in progress |
| rb_drive_low | output | 1 | Ready/busy pin pull-down enable |
| rb_level | output | 1 | Ready/busy pin level with the pull-up applied |

## Verification
A wrong count in the operation timer shows up on `busy` and on the ready/busy pin as an end cycle that is off by one or more cycles. The bench catches this on the first operation of the affected type. A bad value in the captured type or address shows up on bit 7 during the very first busy read, either as a wrong polarity or as polling applied at the wrong address. Toggle state that goes wrong shows up on bit 6 within two reads: it either fails to alternate or changes while a read is held high. A stray restart or a reset that does not clear the state shows up as a changed end cycle or as busy still high.

// File: rtl/pe_status_pkg.sv
package pe_status_pkg;

  typedef enum logic [1:0] {
    OP_PROG  = 2'd0,
    OP_PAGE  = 2'd1,
    OP_BLOCK = 2'd2,
    OP_CHIP  = 2'd3
  } pe_op_e;

  // Busy length in cycles for a given operation type.
  function automatic int unsigned op_cycles(pe_op_e op, int unsigned t_prog,
                                            int unsigned t_page, int unsigned t_block,
                                            int unsigned t_chip);
    case (op)
      OP_PROG:  return t_prog;
      OP_PAGE:  return t_page;
      OP_BLOCK: return t_block;
      default:  return t_chip;
    endcase
  endfunction

  function automatic int unsigned max4(int unsigned a, int unsigned b,
                                       int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // Value of the polling bit while busy: a program inverts the written bit, an erase reads 0.
  function automatic logic poll_bit(pe_op_e op, logic written_bit);
    return (op == OP_PROG) ? ~written_bit : 1'b0;
  endfunction

endpackage

// File: rtl/pe_op_timer.sv
module pe_op_timer
  import pe_status_pkg::*;
#(
  parameter int unsigned T_PROG  = 24,
  parameter int unsigned T_PAGE  = 40,
  parameter int unsigned T_BLOCK = 48,
  parameter int unsigned T_CHIP  = 64,
  parameter int unsigned CW      = 7
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  pe_op_e op,
  output logic   busy,
  output pe_op_e op_q,
  output logic   launch
);

  localparam int unsigned MAXD = max4(T_PROG, T_PAGE, T_BLOCK, T_CHIP);

  logic [CW-1:0] cnt;

  // A start is taken only when idle.
  assign launch = start & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      op_q <= OP_PROG;
    end else if (launch) begin
      busy <= 1'b1;
      cnt  <= CW'(op_cycles(op, T_PROG, T_PAGE, T_BLOCK, T_CHIP) - 1);
      op_q <= op;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  // R2: an accepted start loads the remaining count for its type
  p_load_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (busy && (32'(cnt) + 1 == op_cycles($past(op), T_PROG, T_PAGE, T_BLOCK, T_CHIP))));

  // R2: the count never exceeds the longest operation
  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (32'(cnt) < MAXD));

  // R3: a strobe during busy neither reloads the count nor changes the type
  p_no_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && cnt != '0) |=> (busy && cnt == $past(cnt) - 1'b1 && $stable(op_q)));

endmodule

// File: rtl/pe_toggle_track.sv
module pe_toggle_track (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic launch,
  input  logic rd_active,
  output logic tog_bit
);

  logic rd_prev;
  logic tog_q;
  logic rd_rise;

  assign rd_rise = rd_active & ~rd_prev;
  // The flipped value is shown from the first cycle of a read and held.
  assign tog_bit = tog_q ^ (busy & rd_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_prev <= 1'b0;
      tog_q   <= 1'b0;
    end else begin
      rd_prev <= rd_active;
      if (launch)               tog_q <= 1'b0;
      else if (busy && rd_rise) tog_q <= ~tog_q;
    end
  end

  // R6: each read start during busy flips the stored toggle
  p_flip_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_rise && !launch) |=> (tog_q != $past(tog_q)));

  // R6: without a read start the toggle holds
  p_hold_no_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_rise && !launch) |=> $stable(tog_q));

endmodule

// File: rtl/pe_status_mux.sv
module pe_status_mux
  import pe_status_pkg::*;
#(
  parameter int unsigned AW = 18,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic [AW-1:0] start_addr,
  input  logic [DW-1:0] start_data,
  input  logic          busy,
  input  pe_op_e        op_q,
  input  logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] arr_data,
  input  logic          tog_bit,
  output logic [DW-1:0] rd_data
);

  logic [AW-1:0] addr_q;
  logic          wbit_q;
  logic          addr_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wbit_q <= 1'b0;
    end else if (launch) begin
      addr_q <= start_addr;
      wbit_q <= start_data[7];
    end
  end

  assign addr_hit = (rd_addr == addr_q);

  always_comb begin
    rd_data = arr_data;
    if (busy) begin
      rd_data[6] = tog_bit;
      if (op_q != OP_PROG || addr_hit) rd_data[7] = poll_bit(op_q, wbit_q);
    end
  end

  // R5: every erase reads 0 in the polling bit
  p_erase_poll_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q != OP_PROG) |-> (rd_data[7] == 1'b0));

  // R7: idle reads pass the array through
  p_idle_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (rd_data == arr_data));

  // R7: bits other than the two status bits always pass through
  p_low_bits_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[5:0] == arr_data[5:0]);

endmodule

// File: rtl/pe_status_unit.sv
module pe_status_unit
  import pe_status_pkg::*;
#(
  parameter int unsigned AW      = 18,
  parameter int unsigned DW      = 16,
  parameter int unsigned T_PROG  = 24,
  parameter int unsigned T_PAGE  = 40,
  parameter int unsigned T_BLOCK = 48,
  parameter int unsigned T_CHIP  = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    start_op,
  input  logic [AW-1:0] start_addr,
  input  logic [DW-1:0] start_data,
  input  logic          rd_active,
  input  logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] arr_data,
  output logic [DW-1:0] rd_data,
  output logic          busy,
  output logic          rb_drive_low,
  output logic          rb_level
);

  localparam int unsigned MAXD = max4(T_PROG, T_PAGE, T_BLOCK, T_CHIP);
  localparam int unsigned CW   = (MAXD < 2) ? 1 : $clog2(MAXD);

  pe_op_e op_in;
  pe_op_e op_q;
  logic   launch;
  logic   tog_bit;

  assign op_in = pe_op_e'(start_op);

  pe_op_timer #(
    .T_PROG(T_PROG), .T_PAGE(T_PAGE), .T_BLOCK(T_BLOCK), .T_CHIP(T_CHIP), .CW(CW)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op_in),
    .busy(busy), .op_q(op_q), .launch(launch)
  );

  pe_toggle_track u_toggle (
    .clk(clk), .rst_n(rst_n), .busy(busy), .launch(launch),
    .rd_active(rd_active), .tog_bit(tog_bit)
  );

  pe_status_mux #(.AW(AW), .DW(DW)) u_mux (
    .clk(clk), .rst_n(rst_n), .launch(launch),
    .start_addr(start_addr), .start_data(start_data),
    .busy(busy), .op_q(op_q), .rd_addr(rd_addr), .arr_data(arr_data),
    .tog_bit(tog_bit), .rd_data(rd_data)
  );

  // Open-drain pin: pull low while busy, pull-up gives 1 otherwise.
  assign rb_drive_low = busy;
  assign rb_level     = ~rb_drive_low;

  // R8: the pin reads low for the whole busy period
  p_pin_low_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!rb_level && rb_drive_low));

  // R2: busy rises only after an accepted start
  p_busy_needs_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !launch) |=> !busy);

endmodule

// File: tb/pe_status_unit_bench.sv
module pe_status_unit_bench;

  localparam int AW = 18;
  localparam int DW = 16;
  localparam int TP = 24, TG = 40, TB = 48, TC = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    start_op = 2'd0;
  logic [AW-1:0] start_addr = '0;
  logic [DW-1:0] start_data = '0;
  logic          rd_active = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] arr_data = 16'h0000;
  logic [DW-1:0] rd_data;
  logic          busy, rb_drive_low, rb_level;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pe_status_unit #(.AW(AW), .DW(DW), .T_PROG(TP), .T_PAGE(TG), .T_BLOCK(TB), .T_CHIP(TC))
  u_pe_status_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .start_op(start_op),
    .start_addr(start_addr), .start_data(start_data), .rd_active(rd_active),
    .rd_addr(rd_addr), .arr_data(arr_data), .rd_data(rd_data), .busy(busy),
    .rb_drive_low(rb_drive_low), .rb_level(rb_level)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Pulse start at a falling edge; returns after the capturing edge.
  task automatic kick(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    start = 1'b1; start_op = op; start_addr = a; start_data = d;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Count falling edges with busy high, first one already seen.
  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic read_pulse(output logic [DW-1:0] v);
    @(negedge clk);
    rd_active = 1'b1;
    #1 v = rd_data;
    @(negedge clk);
    rd_active = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    arr_data = 16'h5A5A;
    #1;
    chk("R1 busy", 32'(busy), 0);
    chk("R1 drive_low", 32'(rb_drive_low), 0);
    chk("R1 level", 32'(rb_level), 1);
    chk("R1 rd_data", 32'(rd_data), 32'h5A5A);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after release", 32'(busy), 0);
  endtask

  task automatic t_durations;
    int n;
    int exp_len [4] = '{TP, TG, TB, TC};
    for (int op = 0; op < 4; op++) begin
      kick(2'(op), 18'h00100, 16'h0000);
      chk("R8 drive_low while busy", 32'(rb_drive_low), 1);
      chk("R8 level while busy", 32'(rb_level), 0);
      wait_idle(n);
      chk($sformatf("R2 length op%0d", op), 32'(n), 32'(exp_len[op]));
      chk("R8 level after done", 32'(rb_level), 1);
    end
  endtask

  task automatic t_ignore_restart;
    int n;
    kick(2'd0, 18'h00200, 16'h0080);
    n = 1;
    repeat (4) begin @(negedge clk); n++; end
    start = 1'b1; start_op = 2'd3; start_addr = 18'h00333; start_data = 16'h0000;
    @(negedge clk); n++;
    start = 1'b0;
    rd_addr = 18'h00200; arr_data = 16'h0000;
    #1 chk("R3 type and address kept", 32'(rd_data[7]), 0);
    while (busy && n < 1000) begin @(negedge clk); if (busy) n++; end
    chk("R3 end cycle unchanged", 32'(n), 32'(TP));
  endtask

  task automatic t_prog_poll;
    int n;
    kick(2'd0, 18'h01234, 16'h0080);
    arr_data = 16'h12B4; rd_addr = 18'h01234;
    #1 chk("R4 poll at address", 32'(rd_data[7]), 0);
    chk("R7 other bits while busy", 32'(rd_data & 16'hFF3F), 32'h1234);
    rd_addr = 18'h01235;
    #1 chk("R4 other address", 32'(rd_data[7]), 1);
    wait_idle(n);
    rd_addr = 18'h01234;
    #1 chk("R7 true data after program", 32'(rd_data), 32'h12B4);
    kick(2'd0, 18'h00010, 16'h0000);
    arr_data = 16'h0000; rd_addr = 18'h00010;
    #1 chk("R4 poll of zero bit", 32'(rd_data[7]), 1);
    wait_idle(n);
  endtask

  task automatic t_erase_poll;
    int n;
    for (int op = 1; op < 4; op++) begin
      kick(2'(op), 18'h00000, 16'h0080);
      arr_data = 16'hFFFF; rd_addr = 18'h3FFFF;
      #1 chk($sformatf("R5 erase poll op%0d", op), 32'(rd_data[7]), 0);
      wait_idle(n);
      #1 chk("R7 erased value after done", 32'(rd_data), 32'hFFFF);
    end
  endtask

  task automatic t_toggle;
    logic [DW-1:0] v;
    int n;
    arr_data = 16'h0000;
    kick(2'd2, 18'h00000, 16'h0000);
    @(negedge clk);
    rd_active = 1'b1;
    #1 chk("R6 first read", 32'(rd_data[6]), 1);
    @(negedge clk);
    #1 chk("R6 held read", 32'(rd_data[6]), 1);
    @(negedge clk);
    #1 chk("R6 held read later", 32'(rd_data[6]), 1);
    rd_active = 1'b0;
    read_pulse(v);
    chk("R6 second read", 32'(v[6]), 0);
    read_pulse(v);
    chk("R6 third read", 32'(v[6]), 1);
    wait_idle(n);
    read_pulse(v);
    chk("R7 no toggle after done a", 32'(v[6]), 0);
    read_pulse(v);
    chk("R7 no toggle after done b", 32'(v[6]), 0);
  endtask

  task automatic t_reset_mid;
    logic [DW-1:0] v;
    kick(2'd3, 18'h00000, 16'h0000);
    read_pulse(v);
    repeat (5) @(negedge clk);
    arr_data = 16'h00C3;
    rst_n = 1'b0;
    #1 chk("R9 busy cleared at once", 32'(busy), 0);
    chk("R9 pin released", 32'(rb_level), 1);
    chk("R9 reads array", 32'(rd_data), 32'h00C3);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 stays idle", 32'(busy), 0);
    kick(2'd1, 18'h00000, 16'h0000);
    read_pulse(v);
    chk("R9 toggle restarts", 32'(v[6]), 1);
  endtask

  initial begin
    t_reset;
    t_durations;
    t_ignore_restart;
    t_prog_poll;
    t_erase_poll;
    t_toggle;
    t_reset_mid;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule